// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the programming and progress state of a single-channel bus-master DMA engine that serves a SCSI core. Software programs a start count, a start address and a start descriptor-list address, then writes a command word. A start command copies the three start values into their working copies, clears the status flags and enables DMA toward the core. An idle command disables DMA. An abort command sends a one-cycle cancel pulse to the core. A blast command is accepted and has no effect.

While a transfer runs, the SCSI core presents transfer requests with a length and a direction. The block checks the direction against the programmed one and limits the length to the remaining working count. On the clock edge it subtracts the granted length from the working count and adds it to the working address. When the core reports that the command is complete, the working count is forced to zero and the done flag is set.

Status flags can be cleared in one of two ways, chosen by an input. In the first, software writes 1s to clear them. In the second, reading the status register clears them.

Top module: `dma_ch_regs`

## Requirements
- R1: After reset, the working address reads 0xFFFFFFFF and the working descriptor address reads 0xFFFFFFFD. The command, start count, start address, start descriptor, working count and status all read 0, and dma_en and core_cancel are low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor. Reads return the register in the same cycle. Writes to indices 1, 2 and 6 store the value. Writes to indices 3, 4 and 7 change nothing.
- R3: A write to index 0 stores the command word, and its bits [1:0] select the operation.
  - Value 3 (start) copies index 1 to 3, index 2 to 4 and index 6 to 7, clears all six status bits and sets dma_en from the next cycle.
  - Value 0 (idle) clears dma_en.
  - Value 1 (blast) changes only the stored command.
- R4: A command write with operation 2 (abort) drives core_cancel high for exactly the one cycle after the write.
- R5: A transfer request is accepted when xfer_to_mem equals command bit 7 (1 means the device writes memory). xfer_grant is the smaller of xfer_len and the working count. On the edge, the working count decreases by the grant and the working address increases by it.
- R6: A request whose direction differs from command bit 7 is rejected: xfer_accept is 0, xfer_grant is 0, and the working registers do not change.
- R7: xfer_complete forces the working count to 0 and sets status bit 3 (done) on the next edge. This set wins over any clear in the same cycle, and it wins over a start load of the working count.
- R8: With stat_rd_clears low, writing index 5 clears those of bits 1 (error), 2 (abort) and 3 (done) that are written as 1. Reads then have no side effect.
- R9: With stat_rd_clears high, writes to index 5 are ignored. A read of index 5 returns the flags and then clears bits 1 to 3 on that edge.
- R10: A read of index 5 returns bit 4 set whenever core_irq is high, in addition to the stored flags.
- R11: When a start command and an accepted transfer request fall in the same cycle, the start load wins and the grant is not applied to the working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_idx, combinational |
| stat_rd_clears | input | 1 | 1: status cleared by read; 0: cleared by writing 1s |
| core_irq | input | 1 | Interrupt flag of the SCSI core |
| xfer_req | input | 1 | Transfer request from the core |
| xfer_to_mem | input | 1 | Request direction, 1 = device writes memory |
| xfer_len | input | DW | Requested byte length |
| xfer_accept | output | 1 | Request direction matches the command |
| xfer_grant | output | DW | Granted length, capped by the working count |
| xfer_complete | input | 1 | Command-complete pulse from the core |
| dma_en | output | 1 | DMA enabled toward the core |
| core_cancel | output | 1 | One-cycle cancel pulse toward the core |

## Verification
Two same-cycle collisions matter most. The first is a completion pulse arriving together with a status clear, whether by a write of 1s or by a read in read-clear mode. The second is a start command arriving together with an accepted transfer request or a completion.

The directed phase drives each collision deliberately. It then reads the status and working count, which must show the done flag set, and the start load or the zeroed count as specified. The random phase strobes requests, completions, reads and writes independently in every cycle, so these overlaps recur many times. A cycle-level reference model in the bench judges every output.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

   typedef enum logic [2:0] {
      IX_CMD  = 3'd0,
      IX_SCNT = 3'd1,
      IX_SADR = 3'd2,
      IX_WCNT = 3'd3,
      IX_WADR = 3'd4,
      IX_STAT = 3'd5,
      IX_SDSC = 3'd6,
      IX_WDSC = 3'd7
   } reg_ix_e;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BLAST = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } dma_op_e;

   localparam int STAT_W      = 6;
   localparam int ST_DONE     = 3;
   localparam int ST_IRQ      = 4;
   localparam int CMD_DIR_BIT = 7;
   // flags that a status clear (write or read) may touch: error, abort, done
   localparam logic [STAT_W-1:0] ST_CLEARABLE = 6'b00_1110;

endpackage

// File: rtl/dma_ch_cmd.sv
module dma_ch_cmd
   import dma_ch_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cmd_q,
   output logic          start_o,
   output logic          dma_en_o,
   output logic          cancel_o
);

   dma_op_e op;

   always_comb begin
      op      = dma_op_e'(wdata[1:0]);
      start_o = wr_cmd && (op == OP_START);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         dma_en_o <= 1'b0;
         cancel_o <= 1'b0;
      end else begin
         cancel_o <= wr_cmd && (op == OP_ABORT);
         if (wr_cmd) begin
            cmd_q <= wdata;
            if (op == OP_START)
               dma_en_o <= 1'b1;
            else if (op == OP_IDLE)
               dma_en_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dma_ch_status.sv
module dma_ch_status
   import dma_ch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic              rd_stat,
   input  logic              rd_clr_mode,
   input  logic [STAT_W-1:0] wbits,
   input  logic              start,
   input  logic              done,
   output logic [STAT_W-1:0] stat_q
);

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      logic set_b;
      logic clr_b;
      always_comb begin
         set_b = (i == ST_DONE) && done;
         clr_b = start
               | (wr_stat && !rd_clr_mode && ST_CLEARABLE[i] && wbits[i])
               | (rd_stat &&  rd_clr_mode && ST_CLEARABLE[i]);
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            stat_q[i] <= 1'b0;
         else
            stat_q[i] <= set_b | (stat_q[i] & ~clr_b);
      end
   end

endmodule

// File: rtl/dma_ch_work.sv
module dma_ch_work #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          done,
   input  logic [DW-1:0] scnt,
   input  logic [DW-1:0] sadr,
   input  logic [DW-1:0] sdsc,
   input  logic          cmd_dir,
   input  logic          req,
   input  logic          to_mem,
   input  logic [DW-1:0] len,
   output logic          accept,
   output logic [DW-1:0] grant,
   output logic [DW-1:0] wcnt_q,
   output logic [DW-1:0] wadr_q,
   output logic [DW-1:0] wdsc_q
);

   localparam logic [DW-1:0] WADR_INIT = '1;
   localparam logic [DW-1:0] WDSC_INIT = ~(DW'(2));

   always_comb begin
      accept = req && (to_mem == cmd_dir);
      if (!accept)
         grant = '0;
      else if (len < wcnt_q)
         grant = len;
      else
         grant = wcnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         wadr_q <= WADR_INIT;
         wdsc_q <= WDSC_INIT;
      end else begin
         if (start) begin
            wcnt_q <= scnt;
            wadr_q <= sadr;
            wdsc_q <= sdsc;
         end else if (accept) begin
            wcnt_q <= wcnt_q - grant;
            wadr_q <= wadr_q + grant;
         end
         if (done)
            wcnt_q <= '0;
      end
   end

endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
   import dma_ch_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [2:0]    reg_idx,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          stat_rd_clears,
   input  logic          core_irq,
   input  logic          xfer_req,
   input  logic          xfer_to_mem,
   input  logic [DW-1:0] xfer_len,
   output logic          xfer_accept,
   output logic [DW-1:0] xfer_grant,
   input  logic          xfer_complete,
   output logic          dma_en,
   output logic          core_cancel
);

   if (DW < 16 || DW > 64) begin : g_bad_dw
      $error("dma_ch_regs: DW must lie in 16..64");
   end

   logic [DW-1:0]     cmd_q, scnt_q, sadr_q, sdsc_q;
   logic [DW-1:0]     wcnt_q, wadr_q, wdsc_q;
   logic [STAT_W-1:0] stat_q;
   logic              start_pulse;
   logic              wr_cmd, wr_stat, rd_stat;

   always_comb begin
      wr_cmd  = reg_wr && (reg_idx == IX_CMD);
      wr_stat = reg_wr && (reg_idx == IX_STAT);
      rd_stat = reg_rd && (reg_idx == IX_STAT);
   end

   dma_ch_cmd #(.DW(DW)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_cmd),
      .wdata    (reg_wdata),
      .cmd_q    (cmd_q),
      .start_o  (start_pulse),
      .dma_en_o (dma_en),
      .cancel_o (core_cancel)
   );

   dma_ch_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stat     (wr_stat),
      .rd_stat     (rd_stat),
      .rd_clr_mode (stat_rd_clears),
      .wbits       (reg_wdata[STAT_W-1:0]),
      .start       (start_pulse),
      .done        (xfer_complete),
      .stat_q      (stat_q)
   );

   dma_ch_work #(.DW(DW)) u_work (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_pulse),
      .done    (xfer_complete),
      .scnt    (scnt_q),
      .sadr    (sadr_q),
      .sdsc    (sdsc_q),
      .cmd_dir (cmd_q[CMD_DIR_BIT]),
      .req     (xfer_req),
      .to_mem  (xfer_to_mem),
      .len     (xfer_len),
      .accept  (xfer_accept),
      .grant   (xfer_grant),
      .wcnt_q  (wcnt_q),
      .wadr_q  (wadr_q),
      .wdsc_q  (wdsc_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt_q <= '0;
         sadr_q <= '0;
         sdsc_q <= '0;
      end else if (reg_wr) begin
         case (reg_ix_e'(reg_idx))
            IX_SCNT: scnt_q <= reg_wdata;
            IX_SADR: sadr_q <= reg_wdata;
            IX_SDSC: sdsc_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      logic [STAT_W-1:0] st_view;
      st_view         = stat_q;
      st_view[ST_IRQ] = stat_q[ST_IRQ] | core_irq;
      case (reg_ix_e'(reg_idx))
         IX_CMD:  reg_rdata = cmd_q;
         IX_SCNT: reg_rdata = scnt_q;
         IX_SADR: reg_rdata = sadr_q;
         IX_WCNT: reg_rdata = wcnt_q;
         IX_WADR: reg_rdata = wadr_q;
         IX_STAT: reg_rdata = DW'(st_view);
         IX_SDSC: reg_rdata = sdsc_q;
         default: reg_rdata = wdsc_q;
      endcase
   end

endmodule

// File: rtl/dma_ch_regs_chk.sv
module dma_ch_regs_chk
   import dma_ch_pkg::*;
#(
   parameter int DW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [2:0]        reg_idx,
   input logic [DW-1:0]     reg_wdata,
   input logic              xfer_req,
   input logic              xfer_accept,
   input logic [DW-1:0]     xfer_grant,
   input logic              xfer_complete,
   input logic              dma_en,
   input logic              core_cancel,
   input logic              start_pulse,
   input logic [STAT_W-1:0] stat_q,
   input logic [DW-1:0]     wcnt_q,
   input logic [DW-1:0]     wadr_q
);

   // R4: cancel lasts a single cycle
   p_cancel_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_cancel |=> !core_cancel);

   // R3: enable rises only after a start command write
   p_en_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_en) |-> $past(reg_wr && reg_idx == 3'd0 && reg_wdata[1:0] == 2'd3));

   // R7: completion sets done and empties the working count
   p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_complete |=> (stat_q[ST_DONE] && wcnt_q == '0));

   // R6: rejected request leaves the working address alone
   p_reject_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_accept && !start_pulse) |=> $stable(wadr_q));

   // R5: grant never exceeds the remaining count
   p_grant_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_grant <= wcnt_q);

   // R2: a write to the working count by software changes nothing
   p_wcnt_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == 3'd3 && !xfer_accept && !xfer_complete) |=> $stable(wcnt_q));

endmodule

bind dma_ch_regs dma_ch_regs_chk #(.DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_idx       (reg_idx),
   .reg_wdata     (reg_wdata),
   .xfer_req      (xfer_req),
   .xfer_accept   (xfer_accept),
   .xfer_grant    (xfer_grant),
   .xfer_complete (xfer_complete),
   .dma_en        (dma_en),
   .core_cancel   (core_cancel),
   .start_pulse   (start_pulse),
   .stat_q        (stat_q),
   .wcnt_q        (wcnt_q),
   .wadr_q        (wadr_q)
);

// File: tb/dma_ch_regs_bench.sv
module dma_ch_regs_bench;

   localparam int CLK_P = 10;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]    reg_idx = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          stat_rd_clears = 1'b0, core_irq = 1'b0;
   logic          xfer_req = 1'b0, xfer_to_mem = 1'b0;
   logic [DW-1:0] xfer_len = '0;
   logic          xfer_accept;
   logic [DW-1:0] xfer_grant;
   logic          xfer_complete = 1'b0;
   logic          dma_en, core_cancel;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state
   logic [31:0] m_cmd, m_scnt, m_sadr, m_wcnt, m_wadr, m_sdsc, m_wdsc;
   logic [5:0]  m_stat;
   logic        m_en, m_cancel;

   always #(CLK_P/2) clk = ~clk;

   dma_ch_regs #(.DW(DW)) u_dma_ch_regs (.*);

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %08h expected %08h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(logic [2:0] ix);
      case (ix)
         3'd0: return m_cmd;
         3'd1: return m_scnt;
         3'd2: return m_sadr;
         3'd3: return m_wcnt;
         3'd4: return m_wadr;
         3'd5: return {26'd0, m_stat | {1'b0, core_irq, 4'b0}};
         3'd6: return m_sdsc;
         default: return m_wdsc;
      endcase
   endfunction

   function automatic logic [31:0] exp_grant();
      if (!(xfer_req && xfer_to_mem == m_cmd[7])) return 32'd0;
      return (xfer_len < m_wcnt) ? xfer_len : m_wcnt;
   endfunction

   task automatic model_reset();
      m_cmd = 0; m_scnt = 0; m_sadr = 0; m_wcnt = 0; m_sdsc = 0;
      m_wadr = 32'hFFFF_FFFF; m_wdsc = 32'hFFFF_FFFD;
      m_stat = 0; m_en = 0; m_cancel = 0;
   endtask

   task automatic model_step();
      logic       wcmd, start, acc;
      logic [31:0] g;
      logic [5:0] clr;
      wcmd  = reg_wr && reg_idx == 3'd0;
      start = wcmd && reg_wdata[1:0] == 2'd3;
      acc   = xfer_req && xfer_to_mem == m_cmd[7];
      g     = exp_grant();
      m_cancel = wcmd && reg_wdata[1:0] == 2'd2;
      if (wcmd && reg_wdata[1:0] == 2'd3) m_en = 1;
      else if (wcmd && reg_wdata[1:0] == 2'd0) m_en = 0;
      clr = start ? 6'h3F : 6'h00;
      if (reg_wr && reg_idx == 3'd5 && !stat_rd_clears) clr |= reg_wdata[5:0] & 6'h0E;
      if (reg_rd && reg_idx == 3'd5 && stat_rd_clears)  clr |= 6'h0E;
      m_stat = (m_stat & ~clr) | (xfer_complete ? 6'h08 : 6'h00);
      if (start) begin
         m_wcnt = m_scnt; m_wadr = m_sadr; m_wdsc = m_sdsc;
      end else if (acc) begin
         m_wcnt = m_wcnt - g; m_wadr = m_wadr + g;
      end
      if (xfer_complete) m_wcnt = 0;
      if (reg_wr) begin
         case (reg_idx)
            3'd0: m_cmd  = reg_wdata;
            3'd1: m_scnt = reg_wdata;
            3'd2: m_sadr = reg_wdata;
            3'd6: m_sdsc = reg_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic idle_inputs();
      reg_wr = 0; reg_rd = 0; xfer_req = 0; xfer_complete = 0;
   endtask

   // one cycle: inputs already set; check outputs mid-low-phase, then advance model
   task automatic cyc(string tag);
      @(negedge clk);
      #1;
      chk({tag, " dma_en"}, {31'd0, dma_en}, {31'd0, m_en});
      chk({tag, " cancel"}, {31'd0, core_cancel}, {31'd0, m_cancel});
      if (reg_rd) chk({tag, " rdata"}, reg_rdata, exp_rd(reg_idx));
      if (xfer_req) begin
         chk({tag, " accept"}, {31'd0, xfer_accept},
             {31'd0, xfer_to_mem == m_cmd[7]});
         chk({tag, " grant"}, xfer_grant, exp_grant());
      end
      @(posedge clk);
      #1;
      model_step();
      idle_inputs();
   endtask

   task automatic wr(string tag, logic [2:0] ix, logic [31:0] d);
      reg_wr = 1; reg_idx = ix; reg_wdata = d; cyc(tag);
   endtask

   task automatic rd(string tag, logic [2:0] ix);
      reg_rd = 1; reg_idx = ix; cyc(tag);
   endtask

   task automatic req(string tag, logic dir, logic [31:0] len);
      xfer_req = 1; xfer_to_mem = dir; xfer_len = len; cyc(tag);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired got 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset values
      for (int i = 0; i < 8; i++) rd("R1 reset", 3'(i));
      // R2: programmable registers
      wr("R2 scnt", 3'd1, 32'd100);
      wr("R2 sadr", 3'd2, 32'h0000_1000);
      wr("R2 sdsc", 3'd6, 32'h0000_0040);
      rd("R2 scnt rd", 3'd1);
      // R3: start toward memory
      wr("R3 start", 3'd0, 32'h83);
      rd("R3 wcnt", 3'd3); rd("R3 wadr", 3'd4); rd("R3 wdsc", 3'd7);
      // R5: accepted transfer
      req("R5 req", 1'b1, 32'd30);
      rd("R5 wcnt", 3'd3); rd("R5 wadr", 3'd4);
      // R6: wrong direction
      req("R6 wrong dir", 1'b0, 32'd5);
      rd("R6 wcnt", 3'd3); rd("R6 wadr", 3'd4);
      // R5: cap at remaining count
      req("R5 cap", 1'b1, 32'd500);
      rd("R5 wcnt zero", 3'd3);
      // R2: writes to working registers ignored
      wr("R2 wcnt wr", 3'd3, 32'd77); wr("R2 wadr wr", 3'd4, 32'd5);
      wr("R2 wdsc wr", 3'd7, 32'd9);
      rd("R2 wcnt", 3'd3); rd("R2 wadr", 3'd4); rd("R2 wdsc", 3'd7);
      // R7: completion
      xfer_complete = 1; cyc("R7 complete");
      rd("R7 stat", 3'd5);
      // R10: core interrupt shown in status
      core_irq = 1; rd("R10 irq", 3'd5); core_irq = 0;
      // R8: write-1 clear
      wr("R8 w1c", 3'd5, 32'h08); rd("R8 stat", 3'd5);
      // R7: clear and completion collide, set wins
      reg_wr = 1; reg_idx = 3'd5; reg_wdata = 32'h0E; xfer_complete = 1;
      cyc("R7 collide");
      rd("R7 set wins", 3'd5);
      // R9: read-clear mode
      stat_rd_clears = 1;
      wr("R9 wr ignored", 3'd5, 32'h0E); rd("R9 first rd", 3'd5);
      rd("R9 second rd", 3'd5);
      xfer_complete = 1; reg_rd = 1; reg_idx = 3'd5; cyc("R9 rd+done");
      rd("R9 set wins", 3'd5);
      stat_rd_clears = 0;
      // R4: abort pulse, R3 idle and blast
      wr("R4 abort", 3'd0, 32'h82); rd("R4 pulse", 3'd0); rd("R4 after", 3'd0);
      wr("R3 blast", 3'd1 - 3'd1, 32'h81); rd("R3 blast cmd", 3'd0);
      wr("R3 idle", 3'd0, 32'h80); rd("R3 idle en", 3'd0);
      // R11: start with request in the same cycle
      wr("R11 scnt", 3'd1, 32'd40);
      reg_wr = 1; reg_idx = 3'd0; reg_wdata = 32'h03; xfer_req = 1;
      xfer_to_mem = 1'b1; xfer_len = 32'd4; cyc("R11 start+req");
      rd("R11 wcnt", 3'd3); rd("R11 wadr", 3'd4);
      // R7: start with completion
      reg_wr = 1; reg_idx = 3'd0; reg_wdata = 32'h03; xfer_complete = 1;
      cyc("R7 start+done");
      rd("R7 wcnt", 3'd3); rd("R7 stat after start", 3'd5);

      // random phase
      void'($urandom(32'h5EED_1234));
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] r;
         r = 8'($urandom);
         stat_rd_clears = r[0] & r[1] & r[2];
         core_irq = r[3];
         if (r[4]) begin
            xfer_req = 1; xfer_to_mem = r[5];
            xfer_len = 32'($urandom_range(0, 90));
         end
         xfer_complete = ($urandom_range(0, 19) == 0);
         if ($urandom_range(0, 2) == 0) begin
            reg_wr = 1; reg_idx = 3'($urandom);
            reg_wdata = (reg_idx == 3'd1) ? 32'($urandom_range(0, 400)) : 32'($urandom);
         end else begin
            reg_rd = 1; reg_idx = 3'($urandom);
         end
         cyc("R5 R6 R7 R8 R9 random");
      end
      for (int i = 0; i < 8; i++) rd("R2 final", 3'(i));

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule